// File: doc/BRIEF.md
# Programmable PIO Cycle Timing Generator

This block shapes one programmed-I/O transfer on a parallel drive bus. A transfer runs through three phases: an address-valid setup phase, an active phase with the read or write strobe asserted, and a hold phase with the address still valid. The length of each phase comes from a one-byte timing word. The timing code fields map to clock counts through fixed, non-linear tables rather than plain counts.

Two timing words are held inside the block: one for data-port transfers and one for command/control-port transfers. Both drives on the channel share them. The word for each class can be rewritten at any time through a small load port. A transfer takes the word for its class, and the three decoded lengths, at the clock edge that accepts the start request. When enabled, the drive's ready line can stretch the active phase, up to a bounded timeout. A width flag tells the data path whether the transfer is 8 or 16 bits wide.

Top module: `pio_cycle_timer`

## Requirements
- R1: After reset all outputs are low, the data-class timing word is 0xF5 and the command-class word is 0xDE. A data transfer then takes setup 4, active 8, hold 8 clocks. A command transfer takes setup 4, active 12, hold 4 clocks.
- R2: Timing word bits [7:6] set the setup length: codes 0, 1, 2, 3 give 1, 2, 3, 4 clocks. Setup clocks have `addr_valid` high and both strobes low.
- R3: Timing word bits [5:3] set the hold length: codes 0..7 give 1, 2, 3, 4, 5, 6, 8, 12 clocks. Hold clocks follow the strobe, with `addr_valid` high.
- R4: Timing word bits [2:0] set the active length: codes 0..7 give 2, 3, 4, 5, 6, 8, 12, 16 clocks of strobe.
- R5: `cls_cmd` = 0 at the accepted start selects the data-class word. `cls_cmd` = 1 selects the command-class word. `tim_sel` = 0 or 1 addresses the same two words on the load port.
- R6: A transfer with `is_write` = 1 pulses only `wr_strobe`. A transfer with `is_write` = 0 pulses only `rd_strobe`. The two strobes are never high together.
- R7: `done` is high for exactly one clock: the clock right after the last hold clock. `addr_valid` is low in that clock. `busy` is high from the clock after the accepted start through the `done` clock, and low after it.
- R8: A start request is accepted only while `busy` is low. A request raised during a transfer leaves that transfer unchanged and does not begin a second one.
- R9: With `iordy_en` = 0, a low `iordy` has no effect on the active length.
- R10: With `iordy_en` = 1, a low `iordy` at the last active clock keeps the strobe asserted. The active phase ends at the clock edge where `iordy` is sampled high.
- R11: If `iordy` stays low for TIMEOUT (256) extra active clocks, the active phase ends after A + TIMEOUT clocks and `timeout_err` goes high. `timeout_err` stays high until the next accepted start clears it.
- R12: `cyc_8bit` equals the `narrow` input captured at the accepted start for the whole transfer, and is low while idle.
- R13: A timing-word write during a transfer does not change that transfer's phase lengths. It applies from the next accepted start onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tim_we | input | 1 | Load strobe for a timing word |
| tim_sel | input | 1 | Word to load: 0 data class, 1 command class |
| tim_wdata | input | 8 | New timing word |
| start | input | 1 | Transfer request, taken only when idle |
| cls_cmd | input | 1 | Transfer class: 0 data port, 1 command/control port |
| is_write | input | 1 | Transfer direction: 1 write, 0 read |
| narrow | input | 1 | 1 for an 8-bit data transfer |
| iordy_en | input | 1 | Enables active-phase stretching by `iordy` |
| iordy | input | 1 | Drive ready line, high = ready |
| addr_valid | output | 1 | Address phase qualifier (setup, active, hold) |
| rd_strobe | output | 1 | Read strobe, active phase of a read |
| wr_strobe | output | 1 | Write strobe, active phase of a write |
| done | output | 1 | One-clock end-of-transfer pulse |
| busy | output | 1 | Transfer in progress |
| timeout_err | output | 1 | Ready wait timed out on the last transfer |
| cyc_8bit | output | 1 | Current transfer is 8 bits wide |

## Verification
A wrong phase register or a wrong down-counter value changes how many clocks `addr_valid` is high before, during or after the strobe. That shows as a wrong clock count within the same transfer, or as a missing or doubled `done` one clock after hold. A wrong captured timing word, or a wrong decode, shows in the first transfer that uses it. A stuck wait counter shows either as a strobe that lasts past A + 256 clocks or as an early release with `timeout_err` set. Such errors appear at most a few hundred clocks after the transfer starts.

// File: rtl/pio_timing_pkg.sv
// Package: shared types and code tables for the PIO timing generator.
// Assumes phase lengths never exceed 16 clocks, so CNT_W bits hold length-1.
package pio_timing_pkg;

    localparam int CNT_W = 5;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SETUP  = 3'd1,
        PH_ACTIVE = 3'd2,
        PH_HOLD   = 3'd3,
        PH_DONE   = 3'd4
    } phase_t;

    typedef struct packed {
        logic [CNT_W-1:0] setup;
        logic [CNT_W-1:0] active;
        logic [CNT_W-1:0] hold;
    } phase_len_t;

    // Setup length: a linear code, field value plus one.
    function automatic logic [CNT_W-1:0] setup_clocks(input logic [1:0] code);
        return CNT_W'(code) + CNT_W'(1);
    endfunction

    // Hold length: linear up to six, then eight and twelve.
    function automatic logic [CNT_W-1:0] hold_clocks(input logic [2:0] code);
        logic [CNT_W-1:0] n;
        case (code)
            3'd6:    n = CNT_W'(8);
            3'd7:    n = CNT_W'(12);
            default: n = CNT_W'(code) + CNT_W'(1);
        endcase
        return n;
    endfunction

    // Active length: linear from two to six, then eight, twelve, sixteen.
    function automatic logic [CNT_W-1:0] active_clocks(input logic [2:0] code);
        logic [CNT_W-1:0] n;
        case (code)
            3'd5:    n = CNT_W'(8);
            3'd6:    n = CNT_W'(12);
            3'd7:    n = CNT_W'(16);
            default: n = CNT_W'(code) + CNT_W'(2);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/pio_timing_regs.sv
// Module: holds the two timing words (data class, command class).
// Assumes a write and a read of the same word in one clock returns the old value.
module pio_timing_regs #(
    parameter logic [7:0] DATA_RST = 8'hF5,
    parameter logic [7:0] CMD_RST  = 8'hDE
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic       sel,
    input  logic [7:0] wdata,
    output logic [7:0] data_word,
    output logic [7:0] cmd_word
);

    // Load the addressed word; reset both to their defaults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_word <= DATA_RST;
            cmd_word  <= CMD_RST;
        end else if (we) begin
            if (sel) cmd_word  <= wdata;
            else     data_word <= wdata;
        end
    end

endmodule

// File: rtl/pio_phase_decode.sv
// Module: turns one timing word into three phase lengths in clocks.
// Purely combinational; the fields sit at [7:6] setup, [5:3] hold, [2:0] active.
module pio_phase_decode
    import pio_timing_pkg::*;
(
    input  logic [7:0]  word,
    output phase_len_t  lens
);

    // Split the fields and apply the code tables.
    always_comb begin
        lens.setup  = setup_clocks(word[7:6]);
        lens.hold   = hold_clocks(word[5:3]);
        lens.active = active_clocks(word[2:0]);
    end

endmodule

// File: rtl/pio_cycle_fsm.sv
// Module: phase sequencer with down-counter, ready-line stretch and timeout.
// Assumes every decoded length is at least 1 and at most 2**CNT_W.
module pio_cycle_fsm
    import pio_timing_pkg::*;
#(
    parameter int TIMEOUT = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  phase_len_t lens,
    input  logic       is_write,
    input  logic       narrow,
    input  logic       iordy_en,
    input  logic       iordy,
    output logic       addr_valid,
    output logic       rd_strobe,
    output logic       wr_strobe,
    output logic       done,
    output logic       busy,
    output logic       timeout_err,
    output logic       cyc_8bit
);

    localparam int WAIT_W = $clog2(TIMEOUT + 1);

    phase_t           ph;
    logic [CNT_W-1:0] cnt;
    logic [WAIT_W-1:0] wait_cnt;
    phase_len_t       lens_q;
    logic             wr_q;
    logic             nar_q;
    logic             err_q;
    logic             stall;

    // Drive holds off the end of the active phase.
    assign stall = iordy_en && !iordy;

    // Advance through the phases, counting each one down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph       <= PH_IDLE;
            cnt      <= '0;
            wait_cnt <= '0;
            lens_q   <= '0;
            wr_q     <= 1'b0;
            nar_q    <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            case (ph)
                PH_IDLE: begin
                    if (start) begin
                        ph       <= PH_SETUP;
                        cnt      <= lens.setup - CNT_W'(1);
                        lens_q   <= lens;
                        wr_q     <= is_write;
                        nar_q    <= narrow;
                        err_q    <= 1'b0;
                        wait_cnt <= '0;
                    end
                end
                PH_SETUP: begin
                    if (cnt == '0) begin
                        ph  <= PH_ACTIVE;
                        cnt <= lens_q.active - CNT_W'(1);
                    end else begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                PH_ACTIVE: begin
                    if (cnt != '0) begin
                        cnt <= cnt - CNT_W'(1);
                    end else if (!stall) begin
                        ph  <= PH_HOLD;
                        cnt <= lens_q.hold - CNT_W'(1);
                    end else if (wait_cnt == WAIT_W'(TIMEOUT)) begin
                        ph    <= PH_HOLD;
                        cnt   <= lens_q.hold - CNT_W'(1);
                        err_q <= 1'b1;
                    end else begin
                        wait_cnt <= wait_cnt + WAIT_W'(1);
                    end
                end
                PH_HOLD: begin
                    if (cnt == '0) ph  <= PH_DONE;
                    else           cnt <= cnt - CNT_W'(1);
                end
                PH_DONE: ph <= PH_IDLE;
                default: ph <= PH_IDLE;
            endcase
        end
    end

    // Decode bus outputs from the phase register.
    always_comb begin
        addr_valid  = (ph == PH_SETUP) || (ph == PH_ACTIVE) || (ph == PH_HOLD);
        rd_strobe   = (ph == PH_ACTIVE) && !wr_q;
        wr_strobe   = (ph == PH_ACTIVE) && wr_q;
        done        = (ph == PH_DONE);
        busy        = (ph != PH_IDLE);
        timeout_err = err_q;
        cyc_8bit    = (ph != PH_IDLE) && nar_q;
    end

endmodule

// File: rtl/pio_cycle_timer.sv
// Module: top of the PIO timing generator: timing words, decoders, sequencer.
// Assumes iordy is already synchronised to clk.
module pio_cycle_timer
    import pio_timing_pkg::*;
#(
    parameter int         TIMEOUT  = 256,
    parameter logic [7:0] DATA_RST = 8'hF5,
    parameter logic [7:0] CMD_RST  = 8'hDE
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tim_we,
    input  logic       tim_sel,
    input  logic [7:0] tim_wdata,
    input  logic       start,
    input  logic       cls_cmd,
    input  logic       is_write,
    input  logic       narrow,
    input  logic       iordy_en,
    input  logic       iordy,
    output logic       addr_valid,
    output logic       rd_strobe,
    output logic       wr_strobe,
    output logic       done,
    output logic       busy,
    output logic       timeout_err,
    output logic       cyc_8bit
);

    localparam int N_CLASS = 2;

    logic [7:0] words    [N_CLASS];
    phase_len_t lens_arr [N_CLASS];
    phase_len_t lens_sel;

    pio_timing_regs #(.DATA_RST(DATA_RST), .CMD_RST(CMD_RST)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (tim_we),
        .sel       (tim_sel),
        .wdata     (tim_wdata),
        .data_word (words[0]),
        .cmd_word  (words[1])
    );

    // One decoder per transfer class.
    for (genvar g = 0; g < N_CLASS; g++) begin : g_dec
        pio_phase_decode u_dec (
            .word (words[g]),
            .lens (lens_arr[g])
        );
    end

    // Pick the lengths of the requested class.
    always_comb lens_sel = lens_arr[cls_cmd];

    pio_cycle_fsm #(.TIMEOUT(TIMEOUT)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .lens        (lens_sel),
        .is_write    (is_write),
        .narrow      (narrow),
        .iordy_en    (iordy_en),
        .iordy       (iordy),
        .addr_valid  (addr_valid),
        .rd_strobe   (rd_strobe),
        .wr_strobe   (wr_strobe),
        .done        (done),
        .busy        (busy),
        .timeout_err (timeout_err),
        .cyc_8bit    (cyc_8bit)
    );

endmodule

// File: rtl/pio_cycle_timer_chk.sv
// Checker: port-level protocol properties of pio_cycle_timer, bound below.
module pio_cycle_timer_chk #(
    parameter int TIMEOUT = 256
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic addr_valid,
    input logic rd_strobe,
    input logic wr_strobe,
    input logic done,
    input logic timeout_err
);

    localparam int MAX_ACT = 16 + TIMEOUT;
    localparam int RUN_W   = $clog2(MAX_ACT + 2);

    logic [RUN_W-1:0] run;

    // Length of the current strobe run.
    always_ff @(posedge clk) begin
        if (!rst_n)                  run <= '0;
        else if (rd_strobe || wr_strobe) run <= run + RUN_W'(1);
        else                         run <= '0;
    end

    a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_strobe && wr_strobe));
    a_r6_strobe_in_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe || wr_strobe) |-> addr_valid);
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r7_done_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!addr_valid && $past(addr_valid)));
    a_r7_addr_ends_in_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(addr_valid) |-> done);
    a_r7_busy_covers_addr: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |-> busy);
    a_r11_err_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> !timeout_err);
    a_r11_active_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        run <= RUN_W'(MAX_ACT));

endmodule

bind pio_cycle_timer pio_cycle_timer_chk #(.TIMEOUT(TIMEOUT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .addr_valid  (addr_valid),
    .rd_strobe   (rd_strobe),
    .wr_strobe   (wr_strobe),
    .done        (done),
    .timeout_err (timeout_err)
);

// File: tb/sim_pio_cycle_timer.sv
`timescale 1ns/1ps
// Bench: directed scenarios, one task each, checking phase clock counts.
module sim_pio_cycle_timer;

    localparam int TO = 256;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tim_we = 1'b0, tim_sel = 1'b0;
    logic [7:0] tim_wdata = 8'h00;
    logic       start = 1'b0, cls_cmd = 1'b0, is_write = 1'b0, narrow = 1'b0;
    logic       iordy_en = 1'b0, iordy = 1'b1;
    logic       addr_valid, rd_strobe, wr_strobe, done, busy, timeout_err, cyc_8bit;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    pio_cycle_timer #(.TIMEOUT(TO)) u0 (
        .clk(clk), .rst_n(rst_n), .tim_we(tim_we), .tim_sel(tim_sel),
        .tim_wdata(tim_wdata), .start(start), .cls_cmd(cls_cmd),
        .is_write(is_write), .narrow(narrow), .iordy_en(iordy_en),
        .iordy(iordy), .addr_valid(addr_valid), .rd_strobe(rd_strobe),
        .wr_strobe(wr_strobe), .done(done), .busy(busy),
        .timeout_err(timeout_err), .cyc_8bit(cyc_8bit)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int e_setup(input logic [7:0] w);
        return int'(w[7:6]) + 1;
    endfunction
    function automatic int e_hold(input logic [7:0] w);
        case (w[5:3])
            3'd6: return 8;
            3'd7: return 12;
            default: return int'(w[5:3]) + 1;
        endcase
    endfunction
    function automatic int e_active(input logic [7:0] w);
        case (w[2:0])
            3'd5: return 8;
            3'd6: return 12;
            3'd7: return 16;
            default: return int'(w[2:0]) + 2;
        endcase
    endfunction

    task automatic load_word(input bit sel, input logic [7:0] w);
        @(negedge clk); tim_we = 1'b1; tim_sel = sel; tim_wdata = w;
        @(negedge clk); tim_we = 1'b0;
    endtask

    // Runs one transfer and checks its phase counts and side signals.
    // rel_k: strobe clock at which iordy is raised (0 = high throughout).
    // mid: 1 = extra start during setup, 2 = timing write during setup.
    task automatic run_xfer(input string tag, input bit cmd, input bit wr,
                            input bit nar, input bit ien, input int rel_k,
                            input int es, input int ea, input int eh,
                            input bit e_err, input int mid);
        int s = 0, a = 0, h = 0, wrong = 0, nbad = 0;
        bit prev_av = 1'b0, done_ok = 1'b0, seen = 1'b0;
        @(negedge clk);
        start = 1'b1; cls_cmd = cmd; is_write = wr; narrow = nar;
        iordy_en = ien; iordy = (rel_k == 0);
        @(negedge clk);
        start = 1'b0;
        check(timeout_err == 1'b0, {tag, " R11 err cleared by start"}, timeout_err, 0);
        if (mid == 1) begin start = 1'b1; cls_cmd = ~cmd; end
        if (mid == 2) begin tim_we = 1'b1; tim_sel = cmd; tim_wdata = 8'h00; end
        for (int g = 0; g < 2000; g++) begin
            if (g == 1) begin start = 1'b0; tim_we = 1'b0; end
            if (done) begin
                seen = 1'b1;
                done_ok = prev_av && !addr_valid;
                break;
            end
            if (rd_strobe || wr_strobe) begin
                a++;
                if ((wr && rd_strobe) || (!wr && wr_strobe)) wrong++;
                if (rel_k != 0 && a == rel_k) iordy = 1'b1;
            end else if (addr_valid) begin
                if (a == 0) s++; else h++;
            end
            if (addr_valid && cyc_8bit != nar) nbad++;
            prev_av = addr_valid;
            @(negedge clk);
        end
        start = 1'b0; tim_we = 1'b0;
        check(s == es, {tag, " R2 setup clocks"}, s, es);
        check(a == ea, {tag, " R4 active clocks"}, a, ea);
        check(h == eh, {tag, " R3 hold clocks"}, h, eh);
        check(wrong == 0, {tag, " R6 strobe direction"}, wrong, 0);
        check(seen && done_ok, {tag, " R7 done after hold"}, int'(done_ok), 1);
        check(nbad == 0, {tag, " R12 width flag"}, nbad, 0);
        check(timeout_err == e_err, {tag, " R11 error flag"}, timeout_err, int'(e_err));
        @(negedge clk);
        check(!busy && !done && !addr_valid, {tag, " R7 R8 idle after done"},
              int'(busy) + int'(addr_valid), 0);
        check(cyc_8bit == 1'b0, {tag, " R12 width flag low when idle"}, cyc_8bit, 0);
        iordy = 1'b1;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(!addr_valid && !rd_strobe && !wr_strobe && !done && !busy
              && !timeout_err && !cyc_8bit, "R1 outputs idle in reset",
              int'(busy), 0);
        rst_n = 1'b1;
        run_xfer("default data", 1'b0, 1'b0, 1'b0, 1'b0, 0, 4, 8, 8, 1'b0, 0);
        run_xfer("default cmd R1", 1'b1, 1'b1, 1'b0, 1'b0, 0, 4, 12, 4, 1'b0, 0);
    endtask

    task automatic t_decode;
        logic [7:0] ws [7] = '{8'h00, 8'hFF, 8'h4B, 8'h96, 8'h39, 8'hE8, 8'h64};
        foreach (ws[i]) begin
            load_word(1'b0, ws[i]);
            run_xfer($sformatf("decode %02h R2 R3 R4", ws[i]), 1'b0, i[0], 1'b0,
                     1'b0, 0, e_setup(ws[i]), e_active(ws[i]), e_hold(ws[i]), 1'b0, 0);
        end
    endtask

    task automatic t_class;
        load_word(1'b0, 8'h4B);
        load_word(1'b1, 8'hE8);
        run_xfer("class data R5", 1'b0, 1'b0, 1'b0, 1'b0, 0, 2, 5, 2, 1'b0, 0);
        run_xfer("class cmd R5", 1'b1, 1'b1, 1'b0, 1'b0, 0, 4, 2, 6, 1'b0, 0);
    endtask

    task automatic t_busy_start;
        run_xfer("restart ignored R8", 1'b0, 1'b1, 1'b0, 1'b0, 0, 2, 5, 2, 1'b0, 1);
    endtask

    task automatic t_iordy_off;
        run_xfer("iordy disabled R9", 1'b0, 1'b0, 1'b0, 1'b0, 1000, 2, 5, 2, 1'b0, 0);
    endtask

    task automatic t_iordy_ext;
        run_xfer("iordy stretch R10", 1'b0, 1'b0, 1'b0, 1'b1, 9, 2, 9, 2, 1'b0, 0);
        run_xfer("iordy early R10", 1'b0, 1'b1, 1'b0, 1'b1, 3, 2, 5, 2, 1'b0, 0);
    endtask

    task automatic t_timeout;
        run_xfer("timeout R11", 1'b1, 1'b0, 1'b0, 1'b1, 5000, 4, 2 + TO, 6, 1'b1, 0);
        run_xfer("after timeout R11", 1'b1, 1'b0, 1'b0, 1'b0, 0, 4, 2, 6, 1'b0, 0);
    endtask

    task automatic t_narrow;
        run_xfer("narrow R12", 1'b0, 1'b1, 1'b1, 1'b0, 0, 2, 5, 2, 1'b0, 0);
    endtask

    task automatic t_midwrite;
        run_xfer("write mid-transfer R13", 1'b0, 1'b0, 1'b0, 1'b0, 0, 2, 5, 2, 1'b0, 2);
        run_xfer("new word next transfer R13", 1'b0, 1'b0, 1'b0, 1'b0, 0, 1, 2, 1, 1'b0, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        t_reset();
        t_decode();
        t_class();
        t_busy_start();
        t_iordy_off();
        t_iordy_ext();
        t_timeout();
        t_narrow();
        t_midwrite();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule